// File: doc/BRIEF.md
# Segmented address translation unit

This unit turns a 32-bit virtual address into a 32-bit physical address through a table of four segment descriptors. The two most significant address bits pick a descriptor and the remaining 30 bits are an offset inside that segment. Each descriptor holds a physical base, an inclusive upper limit on the offset, a mapped flag and three access-right flags: read, write and execute. A translated address is the base plus the offset. A request that breaks the segment's rules produces a fault code instead of an address.

Privileged software loads descriptors through a configuration port. A write made without privilege changes nothing and raises a one-cycle flag. Requests arrive over a valid/ready handshake. The result appears one cycle after a request is accepted and is held in a single response register until the consumer accepts it. The request side is ready whenever that register is empty, or is being emptied in the same cycle.

Top module: `seg_xlate`

## Requirements
- R1: Bits [31:30] of `req_vaddr` select the descriptor, and bits [29:0] are the offset.
- R2: When no fault applies, `rsp_paddr` equals the descriptor base plus the zero-extended offset, modulo 2^32.
- R3: An offset strictly greater than the descriptor limit gives fault code 01. An offset equal to the limit translates normally.
- R4: Access kinds are coded 00 read, 01 write and 10 execute. The access-right flags are bit 0 read, bit 1 write and bit 2 execute. A kind whose flag is clear gives fault code 10. Kind 11 always gives fault code 10.
- R5: A request to a descriptor whose mapped flag is clear gives fault code 11.
- R6: When more than one fault applies, the unmapped fault (11) wins over the limit fault (01), and the limit fault wins over the access-right fault (10).
- R7: Whenever the fault code is not 00, `rsp_paddr` is zero.
- R8: A configuration write with `cfg_priv` high stores the descriptor, and requests accepted in later cycles use it. A write with `cfg_priv` low leaves the table unchanged and sets `cfg_denied` high for exactly the next cycle.
- R9: `req_ready` is high when `rsp_valid` is low or `rsp_ready` is high. A request accepted at a clock edge is answered with `rsp_valid` high after that edge. While `rsp_valid` is high and `rsp_ready` is low, the response and its data stay unchanged.
- R10: After reset, `rsp_valid` and `cfg_denied` are low and every descriptor is unmapped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_we | input | 1 | Descriptor write strobe |
| cfg_priv | input | 1 | Writer is privileged |
| cfg_idx | input | 2 | Descriptor to write |
| cfg_base | input | 32 | New physical base |
| cfg_limit | input | 30 | New inclusive offset limit |
| cfg_mapped | input | 1 | New mapped flag |
| cfg_rights | input | 3 | New access rights (bit 0 read, bit 1 write, bit 2 execute) |
| cfg_denied | output | 1 | Pulse one cycle after an unprivileged write |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request can be taken |
| req_vaddr | input | 32 | Virtual address |
| req_kind | input | 2 | Access kind |
| rsp_valid | output | 1 | Response present |
| rsp_ready | input | 1 | Consumer takes response |
| rsp_paddr | output | 32 | Physical address, zero on fault |
| rsp_fault | output | 2 | 00 none, 01 over limit, 10 rights, 11 unmapped |

## Verification
A corrupted descriptor shows up on the first request that uses it. That response carries a wrong address, a wrong fault code, or both, one cycle after acceptance, so each scenario loads descriptors and then probes each field through translations. A stuck or lost response register shows up at once: either `rsp_valid` fails to rise after acceptance, or it fails to drop after the handshake. The hold test also catches data that drifts while the consumer stalls. An unprivileged write that slips into the table becomes visible on the next translation of the segment it targeted.

// File: rtl/seg_xlate_pkg.sv
// Package: shared encodings for the segmented address translation unit.
// Assumes: access kind and fault code are two bits wide at the ports.
package seg_xlate_pkg;

    typedef enum logic [1:0] {
        ACC_READ  = 2'b00,
        ACC_WRITE = 2'b01,
        ACC_EXEC  = 2'b10,
        ACC_RSVD  = 2'b11
    } acc_kind_e;

    typedef enum logic [1:0] {
        FLT_NONE     = 2'b00,
        FLT_LIMIT    = 2'b01,
        FLT_RIGHTS   = 2'b10,
        FLT_UNMAPPED = 2'b11
    } fault_e;

    // Access rights; bit 0 read, bit 1 write, bit 2 execute.
    typedef struct packed {
        logic x;
        logic w;
        logic r;
    } rights_t;

endpackage

// File: rtl/seg_desc_table.sv
// Module: descriptor storage. It holds one base/limit/mapped/rights entry
// per segment, writable only when the writer is privileged. It reports a
// refused write one cycle later.
// Assumes: a read sees the table as it stood before this cycle's write.
module seg_desc_table
    import seg_xlate_pkg::*;
#(
    parameter int PA_W  = 32,
    parameter int OFF_W = 30,
    parameter int SEL_W = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic             wr_priv,
    input  logic [SEL_W-1:0] wr_idx,
    input  logic [PA_W-1:0]  wr_base,
    input  logic [OFF_W-1:0] wr_limit,
    input  logic             wr_mapped,
    input  rights_t          wr_rights,
    input  logic [SEL_W-1:0] rd_idx,
    output logic [PA_W-1:0]  rd_base,
    output logic [OFF_W-1:0] rd_limit,
    output logic             rd_mapped,
    output rights_t          rd_rights,
    output logic             denied
);
    localparam int NSEG = 1 << SEL_W;

    logic [PA_W-1:0]  base_q   [NSEG];
    logic [OFF_W-1:0] limit_q  [NSEG];
    logic             mapped_q [NSEG];
    rights_t          rights_q [NSEG];

    logic wr_ok;
    assign wr_ok = wr_en && wr_priv;

    for (genvar i = 0; i < NSEG; i++) begin : g_entry
        // Load entry i on a privileged write addressed to it.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                base_q[i]   <= '0;
                limit_q[i]  <= '0;
                mapped_q[i] <= 1'b0;
                rights_q[i] <= '0;
            end else if (wr_ok && wr_idx == SEL_W'(i)) begin
                base_q[i]   <= wr_base;
                limit_q[i]  <= wr_limit;
                mapped_q[i] <= wr_mapped;
                rights_q[i] <= wr_rights;
            end
        end

        // R8: a refused write leaves every entry untouched.
        p_refused_keeps_entry_r8: assert property (@(posedge clk) disable iff (!rst_n)
            (wr_en && !wr_priv) |=> ($stable(base_q[i]) && $stable(limit_q[i])
                                     && $stable(mapped_q[i]) && $stable(rights_q[i])));
    end

    // Flag an unprivileged write for one cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) denied <= 1'b0;
        else        denied <= wr_en && !wr_priv;
    end

    // Present the selected entry.
    always_comb begin
        rd_base   = base_q[rd_idx];
        rd_limit  = limit_q[rd_idx];
        rd_mapped = mapped_q[rd_idx];
        rd_rights = rights_q[rd_idx];
    end

    p_denied_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !wr_priv) |=> denied);
    p_denied_only_refused_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_en && !wr_priv) |=> !denied);

endmodule

// File: rtl/seg_check.sv
// Module: combinational limit and rights check with address formation.
// Assumes: PA_W >= OFF_W, so the offset is zero-extended before the add.
module seg_check
    import seg_xlate_pkg::*;
#(
    parameter int PA_W  = 32,
    parameter int OFF_W = 30
) (
    input  logic [PA_W-1:0]  base,
    input  logic [OFF_W-1:0] limit,
    input  logic             mapped,
    input  rights_t          rights,
    input  logic [OFF_W-1:0] offset,
    input  acc_kind_e        kind,
    output logic [PA_W-1:0]  paddr,
    output fault_e           fault
);
    localparam int EXT_W = PA_W - OFF_W;

    logic allowed;

    // Decide whether the access kind is granted by the rights.
    always_comb begin
        unique case (kind)
            ACC_READ:  allowed = rights.r;
            ACC_WRITE: allowed = rights.w;
            ACC_EXEC:  allowed = rights.x;
            default:   allowed = 1'b0;
        endcase
    end

    // Pick the fault by priority and form the address only when clean.
    always_comb begin
        if (!mapped)              fault = FLT_UNMAPPED;
        else if (offset > limit)  fault = FLT_LIMIT;
        else if (!allowed)        fault = FLT_RIGHTS;
        else                      fault = FLT_NONE;
        paddr = (fault == FLT_NONE) ? base + {{EXT_W{1'b0}}, offset} : '0;
    end

endmodule

// File: rtl/seg_resp_stage.sv
// Module: single-entry response register with valid/ready hand-off.
// Assumes: load is asserted only when slot_free is high.
module seg_resp_stage
    import seg_xlate_pkg::*;
#(
    parameter int PA_W = 32
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            load,
    input  logic [PA_W-1:0] in_paddr,
    input  fault_e          in_fault,
    input  logic            out_ready,
    output logic            out_valid,
    output logic [PA_W-1:0] out_paddr,
    output fault_e          out_fault,
    output logic            slot_free
);
    assign slot_free = !out_valid || out_ready;

    // Capture a new result or drain the held one.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            out_paddr <= '0;
            out_fault <= FLT_NONE;
        end else if (load) begin
            out_valid <= 1'b1;
            out_paddr <= in_paddr;
            out_fault <= in_fault;
        end else if (out_ready) begin
            out_valid <= 1'b0;
        end
    end

    p_hold_stable_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_paddr) && $stable(out_fault)));
    p_load_gives_valid_r9: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> out_valid);
    p_no_load_when_full_r9: assert property (@(posedge clk) disable iff (!rst_n)
        load |-> slot_free);
    p_fault_zero_addr_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_fault != FLT_NONE) |-> (out_paddr == '0));

endmodule

// File: rtl/seg_xlate.sv
// Module: top of the segmented address translation unit. It splits the
// virtual address into selector and offset, reads the descriptor, checks it
// and registers the result behind a valid/ready handshake.
// Assumes: a request uses the table as it stood before any same-cycle write.
module seg_xlate
    import seg_xlate_pkg::*;
#(
    parameter int VA_W  = 32,
    parameter int PA_W  = 32,
    parameter int SEL_W = 2,
    parameter int OFF_W = VA_W - SEL_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cfg_we,
    input  logic             cfg_priv,
    input  logic [SEL_W-1:0] cfg_idx,
    input  logic [PA_W-1:0]  cfg_base,
    input  logic [OFF_W-1:0] cfg_limit,
    input  logic             cfg_mapped,
    input  logic [2:0]       cfg_rights,
    output logic             cfg_denied,
    input  logic             req_valid,
    output logic             req_ready,
    input  logic [VA_W-1:0]  req_vaddr,
    input  logic [1:0]       req_kind,
    output logic             rsp_valid,
    input  logic             rsp_ready,
    output logic [PA_W-1:0]  rsp_paddr,
    output logic [1:0]       rsp_fault
);
    logic [SEL_W-1:0] sel;
    logic [OFF_W-1:0] offset;
    logic [PA_W-1:0]  d_base;
    logic [OFF_W-1:0] d_limit;
    logic             d_mapped;
    rights_t          d_rights;
    logic [PA_W-1:0]  x_paddr;
    fault_e           x_fault;
    fault_e           r_fault;
    logic             accept;

    assign sel    = req_vaddr[VA_W-1 -: SEL_W];
    assign offset = req_vaddr[OFF_W-1:0];
    assign accept = req_valid && req_ready;

    seg_desc_table #(.PA_W(PA_W), .OFF_W(OFF_W), .SEL_W(SEL_W)) u_table (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (cfg_we),
        .wr_priv   (cfg_priv),
        .wr_idx    (cfg_idx),
        .wr_base   (cfg_base),
        .wr_limit  (cfg_limit),
        .wr_mapped (cfg_mapped),
        .wr_rights (rights_t'(cfg_rights)),
        .rd_idx    (sel),
        .rd_base   (d_base),
        .rd_limit  (d_limit),
        .rd_mapped (d_mapped),
        .rd_rights (d_rights),
        .denied    (cfg_denied)
    );

    seg_check #(.PA_W(PA_W), .OFF_W(OFF_W)) u_check (
        .base   (d_base),
        .limit  (d_limit),
        .mapped (d_mapped),
        .rights (d_rights),
        .offset (offset),
        .kind   (acc_kind_e'(req_kind)),
        .paddr  (x_paddr),
        .fault  (x_fault)
    );

    seg_resp_stage #(.PA_W(PA_W)) u_resp (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (accept),
        .in_paddr  (x_paddr),
        .in_fault  (x_fault),
        .out_ready (rsp_ready),
        .out_valid (rsp_valid),
        .out_paddr (rsp_paddr),
        .out_fault (r_fault),
        .slot_free (req_ready)
    );

    assign rsp_fault = r_fault;

    p_ready_when_empty_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !rsp_valid |-> req_ready);
    p_drained_after_take_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && rsp_ready && !req_valid) |=> !rsp_valid);

endmodule

// File: tb/seg_xlate_bench.sv
// Bench: directed scenarios for seg_xlate, one task each; each task checks
// its own results at the falling edge, away from the active clock edge.
module seg_xlate_bench;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        cfg_we, cfg_priv, cfg_mapped;
    logic [1:0]  cfg_idx;
    logic [31:0] cfg_base;
    logic [29:0] cfg_limit;
    logic [2:0]  cfg_rights;
    logic        cfg_denied;
    logic        req_valid, req_ready;
    logic [31:0] req_vaddr;
    logic [1:0]  req_kind;
    logic        rsp_valid, rsp_ready;
    logic [31:0] rsp_paddr;
    logic [1:0]  rsp_fault;

    int n_chk  = 0;
    int n_fail = 0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    seg_xlate u_seg_xlate (
        .clk(clk), .rst_n(rst_n),
        .cfg_we(cfg_we), .cfg_priv(cfg_priv), .cfg_idx(cfg_idx),
        .cfg_base(cfg_base), .cfg_limit(cfg_limit), .cfg_mapped(cfg_mapped),
        .cfg_rights(cfg_rights), .cfg_denied(cfg_denied),
        .req_valid(req_valid), .req_ready(req_ready),
        .req_vaddr(req_vaddr), .req_kind(req_kind),
        .rsp_valid(rsp_valid), .rsp_ready(rsp_ready),
        .rsp_paddr(rsp_paddr), .rsp_fault(rsp_fault)
    );

    task automatic chk(input string what, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", what, act, exp);
        end
    endtask

    // Issue one request, check the held response, then drain it.
    task automatic xlate(input logic [31:0] va, input logic [1:0] kind,
                         input logic [31:0] exp_pa, input logic [1:0] exp_flt,
                         input string tag);
        @(negedge clk);
        req_vaddr = va; req_kind = kind; req_valid = 1'b1; rsp_ready = 1'b0;
        @(negedge clk);
        req_valid = 1'b0;
        chk({tag, " rsp_valid"}, 32'(rsp_valid), 32'd1);
        chk({tag, " paddr"}, rsp_paddr, exp_pa);
        chk({tag, " fault"}, 32'(rsp_fault), 32'(exp_flt));
        rsp_ready = 1'b1;
        @(negedge clk);
        rsp_ready = 1'b0;
        chk({tag, " drained R9"}, 32'(rsp_valid), 32'd0);
    endtask

    // One configuration write; checks the refusal flag pulse.
    task automatic cfg(input logic priv, input logic [1:0] idx, input logic [31:0] base,
                       input logic [29:0] lim, input logic mapped, input logic [2:0] rights);
        @(negedge clk);
        cfg_we = 1'b1; cfg_priv = priv; cfg_idx = idx; cfg_base = base;
        cfg_limit = lim; cfg_mapped = mapped; cfg_rights = rights;
        @(negedge clk);
        cfg_we = 1'b0;
        chk("R8 denied flag", 32'(cfg_denied), 32'(!priv));
        @(negedge clk);
        chk("R8 denied one cycle", 32'(cfg_denied), 32'd0);
    endtask

    task automatic t_reset();
        chk("R10 rsp_valid", 32'(rsp_valid), 32'd0);
        chk("R10 cfg_denied", 32'(cfg_denied), 32'd0);
        chk("R9 ready when empty", 32'(req_ready), 32'd1);
        xlate(32'h0000_0010, 2'b00, 32'h0, 2'b11, "R10 unmapped after reset");
        xlate(32'hC000_0000, 2'b10, 32'h0, 2'b11, "R10 seg3 unmapped");
    endtask

    task automatic t_load();
        cfg(1'b1, 2'd0, 32'h1000_0000, 30'h0000_0FFF, 1'b1, 3'b101);
        cfg(1'b1, 2'd1, 32'h8000_0000, 30'h3FFF_FFFF, 1'b1, 3'b011);
        cfg(1'b1, 2'd2, 32'hFFFF_F000, 30'h0000_2000, 1'b1, 3'b111);
        cfg(1'b1, 2'd3, 32'h2000_0000, 30'h0000_00FF, 1'b0, 3'b111);
    endtask

    task automatic t_translate();
        xlate(32'h0000_0010, 2'b00, 32'h1000_0010, 2'b00, "R1 R2 seg0 read");
        xlate(32'h4000_0004, 2'b01, 32'h8000_0004, 2'b00, "R1 R2 seg1 write");
        xlate(32'h8000_1800, 2'b00, 32'h0000_0800, 2'b00, "R2 wrap seg2");
    endtask

    task automatic t_limit();
        xlate(32'h0000_0FFF, 2'b00, 32'h1000_0FFF, 2'b00, "R3 offset equal limit");
        xlate(32'h0000_1000, 2'b00, 32'h0, 2'b01, "R3 R7 offset over limit");
        xlate(32'h8000_2001, 2'b10, 32'h0, 2'b01, "R3 seg2 over limit");
    endtask

    task automatic t_rights();
        xlate(32'h0000_0010, 2'b01, 32'h0, 2'b10, "R4 R7 write to rx seg");
        xlate(32'h0000_0020, 2'b10, 32'h1000_0020, 2'b00, "R4 exec on rx seg");
        xlate(32'h4000_0000, 2'b10, 32'h0, 2'b10, "R4 exec on rw seg");
        xlate(32'h8000_0000, 2'b11, 32'h0, 2'b10, "R4 reserved kind");
    endtask

    task automatic t_priority();
        xlate(32'hC000_0010, 2'b00, 32'h0, 2'b11, "R5 unmapped seg3");
        xlate(32'hFFFF_FFFF, 2'b01, 32'h0, 2'b11, "R6 unmapped over limit");
        xlate(32'h0000_2000, 2'b01, 32'h0, 2'b01, "R6 limit beats rights");
    endtask

    task automatic t_unpriv();
        cfg(1'b0, 2'd3, 32'h3000_0000, 30'h3FFF_FFFF, 1'b1, 3'b111);
        xlate(32'hC000_0010, 2'b00, 32'h0, 2'b11, "R8 refused map stays unmapped");
        cfg(1'b0, 2'd0, 32'h5000_0000, 30'h3FFF_FFFF, 1'b1, 3'b111);
        xlate(32'h0000_0010, 2'b00, 32'h1000_0010, 2'b00, "R8 refused base kept");
        cfg(1'b1, 2'd3, 32'h3000_0000, 30'h0000_00FF, 1'b1, 3'b001);
        xlate(32'hC000_0010, 2'b00, 32'h3000_0010, 2'b00, "R8 privileged map used");
    endtask

    task automatic t_hold();
        @(negedge clk);
        req_vaddr = 32'h4000_0004; req_kind = 2'b01; req_valid = 1'b1; rsp_ready = 1'b0;
        @(negedge clk);
        req_vaddr = 32'h0000_0010; req_kind = 2'b00;
        for (int i = 0; i < 3; i++) begin
            chk("R9 hold valid", 32'(rsp_valid), 32'd1);
            chk("R9 hold paddr", rsp_paddr, 32'h8000_0004);
            chk("R9 not ready while held", 32'(req_ready), 32'd0);
            @(negedge clk);
        end
        rsp_ready = 1'b1;
        #1 chk("R9 ready while draining", 32'(req_ready), 32'd1);
        @(negedge clk);
        req_valid = 1'b0;
        chk("R9 back-to-back valid", 32'(rsp_valid), 32'd1);
        chk("R9 back-to-back paddr", rsp_paddr, 32'h1000_0010);
        @(negedge clk);
        rsp_ready = 1'b0;
        chk("R9 emptied", 32'(rsp_valid), 32'd0);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL R9 watchdog: actual hung expected finished");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        rst_n = 1'b0; cfg_we = 1'b0; cfg_priv = 1'b0; cfg_idx = '0; cfg_base = '0;
        cfg_limit = '0; cfg_mapped = 1'b0; cfg_rights = '0;
        req_valid = 1'b0; req_vaddr = '0; req_kind = '0; rsp_ready = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_load();
        t_translate();
        t_limit();
        t_rights();
        t_priority();
        t_unpriv();
        t_hold();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule